// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block paces the digital side of a successive-approximation converter. It builds a converter-clock tick from the bus clock, or from one of two external tick inputs, through a selectable prescaler. It then walks each conversion through its phases. The first conversion after a start pays a fixed six-tick adder. Every sample after that costs a base time of 25 ticks plus a selectable long-sample adder. When hardware averaging is on, the block gathers 4, 8, 16 or 32 raw codes from the analog stub and reports their truncated mean. When it is off, one code is taken.

The host places a configuration word and an averaging-enable level on the inputs and pulses `start`. The block latches the configuration and emits `smp_start` at the opening of each sample phase. It captures `raw_code` in the cycle where `smp_end` is high. After the last sample it pulses `done` together with the new `result`. With `continuous` high, the next conversion follows at once and skips the six-tick adder.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `smp_start` and `result` are all zero.
- R2: A conversion started from idle raises `done` in the bus cycle after edge T·D, where edge 0 is the one that samples `start`. T = 6 + N·(25 + L) converter ticks, and D is the number of bus cycles per tick.
- R3: L is 3, 5, 7 or 9 for sample-time code `cfg_word[9:8]` = 0..3 when `cfg_word[4]` is 0. It is 13, 17, 21 or 25 for the same codes when `cfg_word[4]` is 1.
- R4: `cfg_word[6:5]` = 0..3 divides by 1, 2, 4 or 8. `cfg_word[1:0]` picks the tick base: 00 every bus cycle, 01 every second bus cycle (so 01 with divide-by-8 gives D = 16), 10 the `alt_tick` input, 11 the `async_tick` input. Ticks run only while `busy`.
- R5: N is 1 when `avg_en` is low, whatever `cfg_word[15:14]` holds. With `avg_en` high, codes 0..3 in `cfg_word[15:14]` give N = 4, 8, 16, 32.
- R6: Each conversion issues exactly N `smp_start` pulses. `result` equals the sum of the N codes captured at `smp_end`, shifted right by log2(N).
- R7: `done` is a single-cycle pulse, once per result. `result` changes only in a cycle with `done` high.
- R8: While `continuous` is high at a `done` edge, the next conversion starts at that same edge without the six-tick adder, so consecutive `done` pulses are N·(25 + L)·D cycles apart. With `continuous` low at that edge, the block returns to idle.
- R9: A `start` pulse while busy, and changes to `cfg_word` or `avg_en` after the start edge, do not alter the running conversion's timing or result.
- R10: Configuration bits 7 and 10 (speed mode) and bits 2, 3 and 11 to 13 have no effect on timing or result.
- R11: With an external tick source, the conversion advances only on tick pulses. While the selected tick input is low, no progress is made and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | CFG_W | Configuration word, latched at start |
| avg_en | input | 1 | Hardware averaging enable, latched at start |
| start | input | 1 | Begin a conversion when idle |
| continuous | input | 1 | Chain conversions back to back |
| alt_tick | input | 1 | Alternate tick source, one pulse per tick |
| async_tick | input | 1 | Asynchronous tick source, already synchronized |
| raw_code | input | CODE_W | Code returned by the analog stub |
| busy | output | 1 | A conversion is in progress |
| smp_start | output | 1 | Pulse at the opening of each sample phase |
| smp_end | output | 1 | High in the cycle `raw_code` is captured |
| done | output | 1 | Result-ready pulse |
| result | output | CODE_W | Averaged conversion result |

## Verification
All eight long-sample codes are swept at divide-by-1 so that a wrong adder shows up as a cycle-count error of at least two. Every divider setting is tried under the bus, half-bus and alternate sources, which separates a divider fault from a tick-base fault. The four averaging counts, plus an averaging field with the enable low, check both the number of sample phases and the shift. The stub returns a distinct pseudo-random code per sample, so a dropped, repeated or misaligned sample changes the mean. Further runs cover back-to-back continuous mode, a disturbed run with a mid-conversion restart attempt and reconfiguration, the ignored speed and spare bits, a stalled asynchronous source, and the slowest corner (N = 32, L = 25, D = 16).

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   localparam int LST_W       = 6;
   localparam int SHIFT_W     = 3;
   localparam int CFG_MIN_W   = 16;

   localparam int CFG_SRC_LSB  = 0;
   localparam int CFG_LSTL_BIT = 4;
   localparam int CFG_DIV_LSB  = 5;
   localparam int CFG_LST_LSB  = 8;
   localparam int CFG_AVG_LSB  = 14;

   typedef enum logic [1:0] {
      SRC_BUS      = 2'b00,
      SRC_BUS_HALF = 2'b01,
      SRC_ALT      = 2'b10,
      SRC_ASYNC    = 2'b11
   } clk_src_e;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_FIRST  = 2'd1,
      PH_SAMPLE = 2'd2
   } phase_e;

   typedef struct packed {
      clk_src_e             src;
      logic [1:0]           div_code;
      logic [LST_W-1:0]     lst_cyc;
      logic [SHIFT_W-1:0]   avg_shift;
   } seq_cfg_t;

   // Long-sample adder: short group steps by 2 from 3, long group by 4 from 13.
   function automatic logic [LST_W-1:0] lst_cycles(input logic lng, input logic [1:0] sel);
      logic [LST_W-1:0] s;
      s = LST_W'(sel);
      return lng ? (LST_W'(13) + (s << 2)) : (LST_W'(3) + (s << 1));
   endfunction

   // log2 of the averaging count: 0 when off, 2..5 when on.
   function automatic logic [SHIFT_W-1:0] avg_shift_of(input logic on, input logic [1:0] sel);
      return on ? (SHIFT_W'(sel) + SHIFT_W'(2)) : '0;
   endfunction

   function automatic seq_cfg_t decode_cfg(input logic [CFG_MIN_W-1:0] w, input logic avg_on);
      seq_cfg_t c;
      c.src       = clk_src_e'(w[CFG_SRC_LSB +: 2]);
      c.div_code  = w[CFG_DIV_LSB +: 2];
      c.lst_cyc   = lst_cycles(w[CFG_LSTL_BIT], w[CFG_LST_LSB +: 2]);
      c.avg_shift = avg_shift_of(avg_on, w[CFG_AVG_LSB +: 2]);
      return c;
   endfunction

endpackage

// File: rtl/adc_seq_clkgen.sv
module adc_seq_clkgen
   import adc_seq_pkg::*;
#(
   parameter int DIV_CODE_W = 2,
   parameter bit EXT_SRC_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  clk_src_e              src,
   input  logic [DIV_CODE_W-1:0] div_code,
   input  logic                  alt_tick,
   input  logic                  async_tick,
   output logic                  ck_tick
);

   localparam int DCNT_W = (1 << DIV_CODE_W) - 1;

   logic              half_q;
   logic [DCNT_W-1:0] dcnt_q;
   logic [DCNT_W-1:0] dlast;
   logic              base_tick;

   initial begin : p_param_check
      assert (DIV_CODE_W >= 1 && DIV_CODE_W <= 3)
         else $error("DIV_CODE_W out of range");
   end

   generate
      if (EXT_SRC_EN) begin : g_ext_src
         always_comb begin
            case (src)
               SRC_BUS:      base_tick = run;
               SRC_BUS_HALF: base_tick = run & half_q;
               SRC_ALT:      base_tick = run & alt_tick;
               default:      base_tick = run & async_tick;
            endcase
         end
      end else begin : g_bus_only
         always_comb begin
            case (src)
               SRC_BUS_HALF: base_tick = run & half_q;
               default:      base_tick = run;
            endcase
         end
      end
   endgenerate

   always_comb begin
      dlast   = {DCNT_W{1'b1}} >> (DCNT_W - int'(div_code));
      ck_tick = base_tick && (dcnt_q == dlast);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         half_q <= 1'b0;
         dcnt_q <= '0;
      end else begin
         half_q <= ~half_q;
         if (base_tick) begin
            dcnt_q <= ck_tick ? '0 : dcnt_q + DCNT_W'(1);
         end
      end
   end

   // Back-to-back ticks only where the divider is 1 and the base runs every cycle.
   p_tick_spacing_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      ck_tick && $past(ck_tick) |-> (div_code == '0) && (src != SRC_BUS_HALF));

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
   import adc_seq_pkg::*;
#(
   parameter int FIRST_CYC = 6,
   parameter int BASE_CYC  = 25
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               continuous,
   input  logic               ck_tick,
   input  logic [LST_W-1:0]   lst_cyc,
   input  logic [SHIFT_W-1:0] avg_shift,
   output logic               busy,
   output logic               smp_start,
   output logic               smp_end,
   output logic               smp_last,
   output logic               done
);

   localparam int PH_W      = $clog2(BASE_CYC + (1 << LST_W) + 1);
   localparam int IDX_W     = (1 << SHIFT_W) - 1;
   localparam bit HAS_FIRST = (FIRST_CYC > 0);
   localparam logic [PH_W-1:0] FIRST_LAST = HAS_FIRST ? PH_W'(FIRST_CYC - 1) : '0;

   phase_e           state_q;
   phase_e           entry_ph;
   logic [PH_W-1:0]  ph_cnt_q;
   logic [PH_W-1:0]  ph_last;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] idx_last;
   logic             ph_end;
   logic             first_end;
   logic             smp_start_q;
   logic             done_q;

   initial begin : p_param_check
      assert (BASE_CYC > 0) else $error("BASE_CYC must be positive");
      assert (FIRST_CYC >= 0 && FIRST_CYC < (1 << PH_W)) else $error("FIRST_CYC does not fit");
   end

   generate
      if (HAS_FIRST) begin : g_first
         assign entry_ph  = PH_FIRST;
         assign first_end = (state_q == PH_FIRST) && ck_tick && (ph_cnt_q == FIRST_LAST);
      end else begin : g_no_first
         assign entry_ph  = PH_SAMPLE;
         assign first_end = 1'b0;
      end
   endgenerate

   always_comb begin
      ph_last  = PH_W'(BASE_CYC) + PH_W'(lst_cyc) - PH_W'(1);
      idx_last = {IDX_W{1'b1}} >> (IDX_W - int'(avg_shift));
      ph_end   = ck_tick && (ph_cnt_q == ph_last);
   end

   assign smp_end   = (state_q == PH_SAMPLE) && ph_end;
   assign smp_last  = smp_end && (idx_q == idx_last);
   assign busy      = (state_q != PH_IDLE);
   assign smp_start = smp_start_q;
   assign done      = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= PH_IDLE;
         ph_cnt_q    <= '0;
         idx_q       <= '0;
         smp_start_q <= 1'b0;
         done_q      <= 1'b0;
      end else begin
         smp_start_q <= 1'b0;
         done_q      <= 1'b0;
         case (state_q)
            PH_IDLE: begin
               if (start) begin
                  state_q     <= entry_ph;
                  ph_cnt_q    <= '0;
                  idx_q       <= '0;
                  smp_start_q <= (entry_ph == PH_SAMPLE);
               end
            end
            PH_FIRST: begin
               if (ck_tick) begin
                  if (first_end) begin
                     state_q     <= PH_SAMPLE;
                     ph_cnt_q    <= '0;
                     smp_start_q <= 1'b1;
                  end else begin
                     ph_cnt_q <= ph_cnt_q + PH_W'(1);
                  end
               end
            end
            PH_SAMPLE: begin
               if (ck_tick) begin
                  if (ph_end) begin
                     ph_cnt_q <= '0;
                     if (idx_q == idx_last) begin
                        done_q <= 1'b1;
                        idx_q  <= '0;
                        if (continuous) begin
                           smp_start_q <= 1'b1;
                        end else begin
                           state_q <= PH_IDLE;
                        end
                     end else begin
                        idx_q       <= idx_q + IDX_W'(1);
                        smp_start_q <= 1'b1;
                     end
                  end else begin
                     ph_cnt_q <= ph_cnt_q + PH_W'(1);
                  end
               end
            end
            default: state_q <= PH_IDLE;
         endcase
      end
   end

   p_start_in_sample_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      smp_start_q |-> (state_q == PH_SAMPLE));

   p_idx_bound_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (idx_q <= idx_last));

   p_cont_keeps_busy_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      done_q && $past(continuous) |-> busy);

endmodule

// File: rtl/adc_seq_avg.sv
module adc_seq_avg
   import adc_seq_pkg::*;
#(
   parameter int CODE_W    = 12,
   parameter int MAX_SHIFT = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp_end,
   input  logic               smp_last,
   input  logic [CODE_W-1:0]  raw_code,
   input  logic [SHIFT_W-1:0] avg_shift,
   output logic [CODE_W-1:0]  result
);

   localparam int ACC_W = CODE_W + MAX_SHIFT;

   logic [ACC_W-1:0]  acc_q;
   logic [ACC_W-1:0]  sum_next;
   logic [CODE_W-1:0] shifted [MAX_SHIFT+1];
   logic [CODE_W-1:0] mean;
   logic [CODE_W-1:0] result_q;

   initial begin : p_param_check
      assert (MAX_SHIFT >= 0 && MAX_SHIFT < (1 << SHIFT_W)) else $error("MAX_SHIFT out of range");
      assert (CODE_W > 0) else $error("CODE_W must be positive");
   end

   assign sum_next = acc_q + ACC_W'(raw_code);

   generate
      for (genvar g = 0; g <= MAX_SHIFT; g++) begin : g_shift
         assign shifted[g] = CODE_W'(sum_next >> g);
      end
   endgenerate

   always_comb begin
      mean = shifted[0];
      for (int k = 1; k <= MAX_SHIFT; k++) begin
         if (int'(avg_shift) == k) mean = shifted[k];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q    <= '0;
         result_q <= '0;
      end else if (smp_end) begin
         if (smp_last) begin
            acc_q    <= '0;
            result_q <= mean;
         end else begin
            acc_q <= sum_next;
         end
      end
   end

   assign result = result_q;

   p_shift_range_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      smp_end |-> (int'(avg_shift) <= MAX_SHIFT));

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
   import adc_seq_pkg::*;
#(
   parameter int CFG_W         = 16,
   parameter int CODE_W        = 12,
   parameter int FIRST_CYC     = 6,
   parameter int BASE_CYC      = 25,
   parameter int MAX_AVG_SHIFT = 5,
   parameter bit EXT_SRC_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CFG_W-1:0]  cfg_word,
   input  logic              avg_en,
   input  logic              start,
   input  logic              continuous,
   input  logic              alt_tick,
   input  logic              async_tick,
   input  logic [CODE_W-1:0] raw_code,
   output logic              busy,
   output logic              smp_start,
   output logic              smp_end,
   output logic              done,
   output logic [CODE_W-1:0] result
);

   seq_cfg_t cfg_q;
   logic     ck_tick;
   logic     smp_last;

   initial begin : p_param_check
      assert (CFG_W >= CFG_MIN_W) else $error("CFG_W narrower than the decoded fields");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (start && !busy) begin
         cfg_q <= decode_cfg(cfg_word[CFG_MIN_W-1:0], avg_en);
      end
   end

   adc_seq_clkgen #(
      .DIV_CODE_W (2),
      .EXT_SRC_EN (EXT_SRC_EN)
   ) clkgen_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (busy),
      .src        (cfg_q.src),
      .div_code   (cfg_q.div_code),
      .alt_tick   (alt_tick),
      .async_tick (async_tick),
      .ck_tick    (ck_tick)
   );

   adc_seq_timer #(
      .FIRST_CYC (FIRST_CYC),
      .BASE_CYC  (BASE_CYC)
   ) timer_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .continuous (continuous),
      .ck_tick    (ck_tick),
      .lst_cyc    (cfg_q.lst_cyc),
      .avg_shift  (cfg_q.avg_shift),
      .busy       (busy),
      .smp_start  (smp_start),
      .smp_end    (smp_end),
      .smp_last   (smp_last),
      .done       (done)
   );

   adc_seq_avg #(
      .CODE_W    (CODE_W),
      .MAX_SHIFT (MAX_AVG_SHIFT)
   ) avg_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_end   (smp_end),
      .smp_last  (smp_last),
      .raw_code  (raw_code),
      .avg_shift (cfg_q.avg_shift),
      .result    (result)
   );

   p_done_single_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_result_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));

endmodule

// File: tb/adc_conv_sequencer_tb_top.sv
`timescale 1ns/1ps
module adc_conv_sequencer_tb_top;

   localparam int LIMIT = 60000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg_word = '0;
   logic        avg_en = 1'b0;
   logic        start = 1'b0;
   logic        continuous = 1'b0;
   logic        alt_tick = 1'b1;
   logic        async_tick = 1'b0;
   logic [11:0] raw_code;
   logic        busy, smp_start, smp_end, done;
   logic [11:0] result;

   int nvec = 0;
   int nbad = 0;
   int stub_idx = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   adc_conv_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .avg_en(avg_en),
      .start(start), .continuous(continuous), .alt_tick(alt_tick),
      .async_tick(async_tick), .raw_code(raw_code), .busy(busy),
      .smp_start(smp_start), .smp_end(smp_end), .done(done), .result(result)
   );

   function automatic int code_of(int i);
      return (i * 733 + 91) % 4096;
   endfunction

   // Analog stub: a new code for every sample phase.
   always @(posedge clk) if (smp_start) stub_idx <= stub_idx + 1;
   assign raw_code = 12'(code_of(stub_idx));

   function automatic int lst_of(logic [15:0] c);
      return c[4] ? 13 + 4 * int'(c[9:8]) : 3 + 2 * int'(c[9:8]);
   endfunction
   function automatic int sh_of(logic [15:0] c, bit ae);
      return ae ? int'(c[15:14]) + 2 : 0;
   endfunction
   function automatic int d_of(logic [15:0] c);
      return (1 << c[6:5]) * ((c[1:0] == 2'b01) ? 2 : 1);
   endfunction
   function automatic int exp_mean(int base, int sh);
      int s = 0;
      for (int j = 1; j <= (1 << sh); j++) s += code_of(base + j);
      return s >> sh;
   endfunction

   task automatic check_eq(string req, string what, int act, int exp);
      nvec++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
   endtask

   // Counts negedges until done is seen; optional disturbance for R9.
   task automatic wait_done(output int cyc, input bit disturb, input logic [15:0] c, input bit ae);
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
         if (disturb && cyc == 5) begin
            start = 1'b1; cfg_word = c ^ 16'hC3F3; avg_en = ~ae;
         end
         if (disturb && cyc == 6) start = 1'b0;
      end while (!done && cyc < LIMIT);
   endtask

   task automatic run_one(logic [15:0] c, bit ae, string req, bit disturb);
      int base, cyc, sh, t;
      base = stub_idx;
      sh = sh_of(c, ae);
      t = 6 + (1 << sh) * (25 + lst_of(c));
      @(negedge clk);
      cfg_word = c; avg_en = ae; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(cyc, disturb, c, ae);
      check_eq(req, "R2 start-to-done cycles", cyc, t * d_of(c));
      check_eq("R6", "mean", int'(result), exp_mean(base, sh));
      check_eq("R6", "sample phases", stub_idx - base, 1 << sh);
      check_eq("R8", "idle after single", int'(busy), 0);
      @(negedge clk);
      check_eq("R7", "done width", int'(done), 0);
      cfg_word = c;
      avg_en = ae;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nbad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin : main
      int cyc, base;
      logic [15:0] c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check_eq("R1", "busy", int'(busy), 0);
      check_eq("R1", "done", int'(done), 0);
      check_eq("R1", "smp_start", int'(smp_start), 0);
      check_eq("R1", "result", int'(result), 0);

      // R2/R3: every long-sample code, bus source, divide by 1
      for (int k = 0; k < 8; k++) begin
         c = '0;
         c[4] = k[2];
         c[9:8] = k[1:0];
         run_one(c, 1'b0, "R3", 1'b0);
      end

      // R4: every divider under bus, half-bus and alternate sources
      for (int s = 0; s < 3; s++) begin
         for (int d = 0; d < 4; d++) begin
            c = '0;
            c[1:0] = s[1:0];
            c[6:5] = d[1:0];
            c[9:8] = 2'd1;
            run_one(c, 1'b0, "R4", 1'b0);
         end
      end

      // R5: averaging counts, and field ignored with averaging off
      for (int a = 0; a < 4; a++) begin
         c = 16'h0200;
         c[15:14] = a[1:0];
         run_one(c, 1'b1, "R5", 1'b0);
      end
      run_one(16'hC200, 1'b0, "R5", 1'b0);

      // R10: speed-mode and spare bits
      run_one(16'h0220 | 16'h0080, 1'b0, "R10", 1'b0);
      run_one(16'h0220 | 16'h0400, 1'b0, "R10", 1'b0);
      run_one(16'h0220 | 16'h3C0C, 1'b1, "R10", 1'b0);

      // R9: restart attempt and reconfiguration mid-conversion
      run_one(16'h4130, 1'b1, "R9", 1'b1);

      // Slowest corner: N=32, L=25, half-bus with divide by 8 (D=16)
      run_one(16'hC371, 1'b1, "R4", 1'b0);

      // R8: continuous mode, N=4, L=5, D=2
      c = 16'h0120;
      base = stub_idx;
      @(negedge clk);
      cfg_word = c; avg_en = 1'b1; continuous = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(cyc, 1'b0, c, 1'b1);
      check_eq("R8", "first conversion cycles", cyc, 2 * (6 + 4 * 30));
      check_eq("R8", "first mean", int'(result), exp_mean(base, 2));
      base = stub_idx;
      wait_done(cyc, 1'b0, c, 1'b1);
      check_eq("R8", "chained interval", cyc, 2 * 4 * 30);
      check_eq("R8", "second mean", int'(result), exp_mean(base, 2));
      check_eq("R8", "still busy", int'(busy), 1);
      base = stub_idx;
      continuous = 1'b0;
      wait_done(cyc, 1'b0, c, 1'b1);
      check_eq("R8", "last chained interval", cyc, 2 * 4 * 30);
      check_eq("R8", "third mean", int'(result), exp_mean(base, 2));
      check_eq("R8", "idle after stop", int'(busy), 0);

      // R11: asynchronous source stalled, then released (L=3, D=2)
      c = 16'h0023;
      base = stub_idx;
      async_tick = 1'b0;
      @(negedge clk);
      cfg_word = c; avg_en = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      begin
         int seen = 0;
         for (int w = 1; w <= 40; w++) begin
            @(negedge clk);
            if (done) seen++;
         end
         check_eq("R11", "done while stalled", seen, 0);
         check_eq("R11", "busy while stalled", int'(busy), 1);
      end
      async_tick = 1'b1;
      wait_done(cyc, 1'b0, c, 1'b0);
      check_eq("R11", "cycles after release", cyc + 40, 40 + 34 * 2);
      check_eq("R11", "mean", int'(result), exp_mean(base, 0));
      async_tick = 1'b0;

      repeat (4) @(negedge clk);
      finished = 1'b1;
      summary();
      $finish;
   end

endmodule